// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through data cache and main memory. CPU stores go into a four-slot queue of 16-byte blocks and are accepted in the same cycle, so the CPU never waits on the memory write. A store to a block that already has a pending slot folds its bytes into that slot instead of taking a new one. Each slot keeps a per-byte valid mask. Slots go to memory one at a time, in the order they were opened.

A cache that misses on a read first looks the address up here. If every byte the read asks for is present in a pending slot, the word is supplied directly. If the block is pending but incomplete, the read is held until that slot has drained. Only a block that is not pending lets the read go to memory. When the cache runs write-back, a dirty victim line can be dropped into the buffer as one full line. The line fill then proceeds and the victim reaches memory later.

Addresses are word addresses (byte address divided by four). A block address is the word address without its two low bits, which select the word inside the block.

Top module: `merge_wbuf`

## Requirements
- R1: After reset no slot is pending: mem_valid is low, and st_ready and vic_ready are high.
- R2: A store to a block with no pending slot is accepted in its cycle when a slot is free. The new slot holds only the enabled bytes, with every other byte zero and its mask bit clear. Word w (word address bits [1:0]) byte b sits at mask bit 4*w+b and data bits [32*w+8*b+7 : 32*w+8*b].
- R3: A store to a block that is already pending merges its enabled bytes into that slot and opens no new slot. It is accepted even when all slots are occupied.
- R4: With all slots occupied, a store that matches no slot is refused (st_ready low) unless the oldest slot drains in that same cycle. The buffer never holds more than four slots.
- R5: Slots are presented to memory oldest first. A merge does not move a slot in that order. Each slot is presented once, with its block address, line data and byte mask.
- R6: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_baddr stays unchanged.
- R7: A read lookup whose block is pending, with every byte requested by rd_be valid, raises rd_fwd and returns the stored word on rd_data in the same cycle.
- R8: A read lookup whose block is pending but lacks a requested byte raises rd_wait and keeps rd_mem_ok low until that slot has drained. A lookup matching no slot raises rd_mem_ok. While rd_valid is high, exactly one of rd_fwd, rd_wait and rd_mem_ok is high.
- R9: A victim line is written with all 16 bytes valid and overwrites a pending slot of the same block. While vic_valid is high, stores are refused.
- R10: A store to the block of the oldest slot in the cycle that slot drains opens a new slot, so its bytes are not lost.
- R11: A stall on a full buffer ends in the cycle the oldest slot drains: with all slots occupied and mem_ready high, a new store is accepted in that cycle.
- R12: On the memory port, every data byte whose mask bit is clear is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_waddr | input | 30 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Store accepted this cycle |
| vic_valid | input | 1 | Victim line request |
| vic_baddr | input | 28 | Victim block address |
| vic_data | input | 128 | Victim line data |
| vic_ready | output | 1 | Victim accepted this cycle |
| rd_valid | input | 1 | Read-miss lookup request |
| rd_waddr | input | 30 | Lookup word address |
| rd_be | input | 4 | Bytes the read needs |
| rd_fwd | output | 1 | Word supplied from the buffer |
| rd_data | output | 32 | Forwarded word |
| rd_wait | output | 1 | Block pending but incomplete; hold the read |
| rd_mem_ok | output | 1 | Read may go to memory |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_baddr | output | 28 | Block address of the offered slot |
| mem_data | output | 128 | Line data of the offered slot |
| mem_mask | output | 16 | Byte mask of the offered slot |
| mem_ready | input | 1 | Memory takes the offered slot |

## Verification
The acceptance signals, the lookup results and the memory port are combinational from the current slots, so they are due in the same cycle as the stimulus. The bench drives just after a falling edge and samples one nanosecond later, before the rising edge. A store, victim or drain changes the slots at the next rising edge, so its effect is checked in the cycle after. The bench keeps an ordered model of the slots, updated at each edge in the order pop, then write. It compares every memory offer during drains against the head of that model.

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        st_valid,
  input  logic [AW-3:0]               st_waddr,
  input  logic [31:0]                 st_data,
  input  logic [3:0]                  st_be,
  output logic                        st_ready,
  input  logic                        vic_valid,
  input  logic [AW-3-$clog2(WORDS):0] vic_baddr,
  input  logic [32*WORDS-1:0]         vic_data,
  output logic                        vic_ready,
  input  logic                        rd_valid,
  input  logic [AW-3:0]               rd_waddr,
  input  logic [3:0]                  rd_be,
  output logic                        rd_fwd,
  output logic [31:0]                 rd_data,
  output logic                        rd_wait,
  output logic                        rd_mem_ok,
  output logic                        mem_valid,
  output logic [AW-3-$clog2(WORDS):0] mem_baddr,
  output logic [32*WORDS-1:0]         mem_data,
  output logic [4*WORDS-1:0]          mem_mask,
  input  logic                        mem_ready
);
  localparam int DW   = 32;
  localparam int BW   = DW / 8;
  localparam int LW   = DW * WORDS;
  localparam int MW   = BW * WORDS;
  localparam int WSEL = $clog2(WORDS);
  localparam int WAW  = AW - 2;
  localparam int TW   = WAW - WSEL;
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;

  logic [DEPTH-1:0] vld_q;
  logic [TW-1:0]    tag_q [DEPTH];
  logic [LW-1:0]    dat_q [DEPTH];
  logic [MW-1:0]    msk_q [DEPTH];
  logic [PW-1:0]    head_q;
  logic [CW-1:0]    cnt_q;

  logic [DEPTH-1:0] st_hitv, vic_hitv, rd_hitv;
  logic [PW-1:0]    st_idx, vic_idx, rd_idx;
  logic             pop, space, st_hit, vic_hit, rd_hit;
  logic             wr_go, wr_hit;
  logic [PW-1:0]    wr_idx, tail;
  logic [TW-1:0]    wr_tag;
  logic [LW-1:0]    wr_line, wr_bits;
  logic [MW-1:0]    wr_mask, st_mask;
  logic [WSEL-1:0]  st_w, rd_w;
  logic [BW-1:0]    rd_have;

  assign mem_valid = cnt_q != '0;
  assign mem_baddr = tag_q[head_q];
  assign mem_data  = dat_q[head_q];
  assign mem_mask  = msk_q[head_q];
  assign pop       = mem_valid && mem_ready;
  assign space     = (cnt_q != CW'(DEPTH)) || pop;
  assign tail      = head_q + cnt_q[PW-1:0];

  always_comb begin
    st_hitv  = '0;
    vic_hitv = '0;
    rd_hitv  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      st_hitv[i]  = vld_q[i] && tag_q[i] == st_waddr[WAW-1:WSEL] && !(pop && PW'(i) == head_q);
      vic_hitv[i] = vld_q[i] && tag_q[i] == vic_baddr && !(pop && PW'(i) == head_q);
      rd_hitv[i]  = vld_q[i] && tag_q[i] == rd_waddr[WAW-1:WSEL];
    end
  end

  always_comb begin
    st_idx  = '0;
    vic_idx = '0;
    rd_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (st_hitv[i])  st_idx  = PW'(i);
      if (vic_hitv[i]) vic_idx = PW'(i);
      if (rd_hitv[i])  rd_idx  = PW'(i);
    end
  end

  assign st_hit  = |st_hitv;
  assign vic_hit = |vic_hitv;
  assign st_w    = st_waddr[WSEL-1:0];
  assign st_mask = MW'(st_be) << (st_w * BW);

  assign vic_ready = vic_hit || space;
  assign st_ready  = !vic_valid && (st_hit || space);

  assign wr_go   = vic_valid ? vic_ready : (st_valid && st_ready);
  assign wr_hit  = vic_valid ? vic_hit   : st_hit;
  assign wr_idx  = vic_valid ? vic_idx   : st_idx;
  assign wr_tag  = vic_valid ? vic_baddr : st_waddr[WAW-1:WSEL];
  assign wr_line = vic_valid ? vic_data  : {WORDS{st_data}};
  assign wr_mask = vic_valid ? {MW{1'b1}} : st_mask;

  always_comb begin
    for (int b = 0; b < MW; b++) wr_bits[b*8 +: 8] = {8{wr_mask[b]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + PW'(1);
      end
      if (wr_go) begin
        if (wr_hit) begin
          dat_q[wr_idx] <= (dat_q[wr_idx] & ~wr_bits) | (wr_line & wr_bits);
          msk_q[wr_idx] <= msk_q[wr_idx] | wr_mask;
        end else begin
          vld_q[tail] <= 1'b1;
          tag_q[tail] <= wr_tag;
          dat_q[tail] <= wr_line & wr_bits;
          msk_q[tail] <= wr_mask;
        end
      end
      cnt_q <= cnt_q + CW'(wr_go && !wr_hit) - CW'(pop);
    end
  end

  assign rd_w      = rd_waddr[WSEL-1:0];
  assign rd_hit    = rd_valid && |rd_hitv;
  assign rd_have   = msk_q[rd_idx][rd_w*BW +: BW];
  assign rd_data   = dat_q[rd_idx][rd_w*DW +: DW];
  assign rd_fwd    = rd_hit && ((rd_have & rd_be) == rd_be);
  assign rd_wait   = rd_hit && !rd_fwd;
  assign rd_mem_ok = rd_valid && !rd_hit;
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
  parameter int DEPTH = 4,
  parameter int TW    = 28,
  parameter int LW    = 128,
  parameter int MW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_ready,
  input logic             vic_valid,
  input logic             vic_ready,
  input logic             rd_valid,
  input logic             rd_fwd,
  input logic             rd_wait,
  input logic             rd_mem_ok,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [TW-1:0]    mem_baddr,
  input logic [LW-1:0]    mem_data,
  input logic [MW-1:0]    mem_mask,
  input logic [$clog2(DEPTH):0] cnt_q,
  input logic [DEPTH-1:0] rd_hitv
);
  logic clean;
  always_comb begin
    clean = 1'b1;
    for (int b = 0; b < MW; b++)
      if (!mem_mask[b] && mem_data[b*8 +: 8] != 8'h00) clean = 1'b0;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ($clog2(DEPTH)+1)'(DEPTH));
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_baddr));
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $countones({rd_fwd, rd_wait, rd_mem_ok}) == 1);
  p_vic_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> !st_ready);
  p_unique_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hitv));
  p_empty_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> vic_ready && (st_ready || vic_valid));
  p_clean_bytes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> clean);
endmodule

bind merge_wbuf merge_wbuf_chk #(.DEPTH(DEPTH), .TW(TW), .LW(LW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .vic_valid(vic_valid),
  .vic_ready(vic_ready), .rd_valid(rd_valid), .rd_fwd(rd_fwd), .rd_wait(rd_wait),
  .rd_mem_ok(rd_mem_ok), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_baddr(mem_baddr), .mem_data(mem_data), .mem_mask(mem_mask),
  .cnt_q(cnt_q), .rd_hitv(rd_hitv)
);

// File: tb/merge_wbuf_tb.sv
`timescale 1ns/1ps
module merge_wbuf_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, st_valid, st_ready, vic_valid, vic_ready, rd_valid;
  logic [29:0]  st_waddr, rd_waddr;
  logic [31:0]  st_data, rd_data;
  logic [3:0]   st_be, rd_be;
  logic [27:0]  vic_baddr, mem_baddr;
  logic [127:0] vic_data, mem_data;
  logic         rd_fwd, rd_wait, rd_mem_ok, mem_valid, mem_ready;
  logic [15:0]  mem_mask;

  merge_wbuf u_dut (.*);

  int checks = 0, errors = 0;

  logic [27:0]  m_tag [8];
  logic [127:0] m_dat [8];
  logic [15:0]  m_msk [8];
  int m_n = 0;

  localparam logic [31:0] T_ADDR [8] = '{32'h100, 32'h104, 32'h200, 32'h10C,
                                         32'h300, 32'h400, 32'h500, 32'h208};
  localparam logic [31:0] T_DATA [8] = '{32'hAAAA0001, 32'hBBBB2222, 32'hCCCC0003, 32'hDDEE0000,
                                         32'h00000005, 32'h00000006, 32'h77777777, 32'h88888888};
  localparam logic [3:0]  T_BE   [8] = '{4'hF, 4'h3, 4'hF, 4'hC, 4'hF, 4'h1, 4'hF, 4'h6};
  localparam logic        T_RDY  [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expand(input logic [15:0] m);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  task automatic model_write(input logic [27:0] tag, input logic [127:0] line, input logic [15:0] msk);
    int hit = -1;
    for (int j = 0; j < m_n; j++) if (m_tag[j] == tag) hit = j;
    if (hit >= 0) begin
      m_dat[hit] = (m_dat[hit] & ~expand(msk)) | (line & expand(msk));
      m_msk[hit] = m_msk[hit] | msk;
    end else begin
      m_tag[m_n] = tag; m_dat[m_n] = line & expand(msk); m_msk[m_n] = msk; m_n++;
    end
  endtask

  task automatic model_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    model_write(a[31:4], {4{d}}, 16'(be) << (a[3:2] * 4));
  endtask

  task automatic model_pop();
    for (int j = 1; j < m_n; j++) begin
      m_tag[j-1] = m_tag[j]; m_dat[j-1] = m_dat[j]; m_msk[j-1] = m_msk[j];
    end
    m_n--;
  endtask

  task automatic drive_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    st_valid = 1'b1; st_waddr = a[31:2]; st_data = d; st_be = be;
  endtask

  task automatic drain(input string req);
    mem_ready = 1'b1; st_valid = 1'b0; vic_valid = 1'b0;
    while (m_n > 0) begin
      #1;
      chk(mem_valid && mem_baddr == m_tag[0], {req, " R5 order"}, 128'(mem_baddr), 128'(m_tag[0]));
      chk(mem_data == m_dat[0], {req, " R5 R12 data"}, mem_data, m_dat[0]);
      chk(mem_mask == m_msk[0], {req, " R5 mask"}, 128'(mem_mask), 128'(m_msk[0]));
      model_pop();
      @(negedge clk);
    end
    #1;
    chk(!mem_valid, {req, " R5 empty after drain"}, 128'(mem_valid), 128'(0));
    mem_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; vic_valid = 1'b0; rd_valid = 1'b0; mem_ready = 1'b0;
    st_waddr = '0; st_data = '0; st_be = '0; rd_waddr = '0; rd_be = '0;
    vic_baddr = '0; vic_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!mem_valid && st_ready && vic_ready, "R1 reset state", {mem_valid, st_ready, vic_ready}, 3'b011);
    @(negedge clk);

    // R2 R3 R4: vector walk with memory stalled
    for (int i = 0; i < 8; i++) begin
      drive_store(T_ADDR[i], T_DATA[i], T_BE[i]);
      #1;
      chk(st_ready == T_RDY[i], $sformatf("R2 R3 R4 vector %0d ready", i), 128'(st_ready), 128'(T_RDY[i]));
      if (T_RDY[i]) model_store(T_ADDR[i], T_DATA[i], T_BE[i]);
      @(negedge clk);
    end
    st_valid = 1'b0;

    // R7 and R8 lookups
    rd_valid = 1'b1; rd_waddr = 30'h100 >> 2; rd_be = 4'hF; #1;
    chk(rd_fwd && rd_data == 32'hAAAA0001, "R7 full word forward", 128'(rd_data), 128'hAAAA0001);
    rd_waddr = 30'h10C >> 2; rd_be = 4'hC; #1;
    chk(rd_fwd && rd_data == 32'hDDEE0000, "R7 R12 partial forward", 128'(rd_data), 128'hDDEE0000);
    rd_waddr = 30'h104 >> 2; rd_be = 4'hF; #1;
    chk(rd_wait && !rd_mem_ok && !rd_fwd, "R8 incomplete block waits", {rd_fwd, rd_wait, rd_mem_ok}, 3'b010);
    rd_be = 4'h3; #1;
    chk(rd_fwd && rd_data[15:0] == 16'h2222, "R7 half word forward", 128'(rd_data[15:0]), 128'h2222);
    rd_waddr = 30'h600 >> 2; rd_be = 4'hF; #1;
    chk(rd_mem_ok && !rd_wait && !rd_fwd, "R8 miss goes to memory", {rd_fwd, rd_wait, rd_mem_ok}, 3'b001);
    rd_waddr = 30'h104 >> 2;
    @(negedge clk);
    #1;
    chk(mem_valid && mem_baddr == 28'h10, "R6 offer held while not ready", 128'(mem_baddr), 128'h10);
    @(negedge clk);
    drain("R3 merge keeps position");
    chk(rd_mem_ok && !rd_wait, "R8 read released after drain", {rd_wait, rd_mem_ok}, 2'b01);
    rd_valid = 1'b0;

    // R11: full, then a store in the cycle the oldest drains
    for (int i = 0; i < 4; i++) begin
      drive_store(32'h1000 + 32'(i) * 16, 32'h11110000 + 32'(i), 4'hF);
      model_store(32'h1000 + 32'(i) * 16, 32'h11110000 + 32'(i), 4'hF);
      @(negedge clk);
    end
    drive_store(32'h2004, 32'h5A5A5A5A, 4'hF); #1;
    chk(!st_ready, "R4 stall when full", 128'(st_ready), 128'(0));
    mem_ready = 1'b1; #1;
    chk(st_ready, "R11 accept as oldest drains", 128'(st_ready), 128'(1));
    model_pop(); model_store(32'h2004, 32'h5A5A5A5A, 4'hF);
    @(negedge clk);
    drain("R11");

    // R10: store to the head block in its drain cycle
    drive_store(32'h700, 32'h00000001, 4'hF); model_store(32'h700, 32'h00000001, 4'hF);
    @(negedge clk);
    drive_store(32'h704, 32'h00000002, 4'hF); mem_ready = 1'b1; #1;
    chk(st_ready && mem_mask == 16'h000F, "R10 head offered before merge", 128'(mem_mask), 128'h000F);
    model_pop(); model_store(32'h704, 32'h00000002, 4'hF);
    @(negedge clk);
    drain("R10 new slot");

    // R9: victim priority and overwrite of a pending block
    drive_store(32'h908, 32'h12345678, 4'hF); model_store(32'h908, 32'h12345678, 4'hF);
    @(negedge clk);
    vic_valid = 1'b1; vic_baddr = 28'h90; vic_data = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    drive_store(32'hA00, 32'h9, 4'hF); #1;
    chk(!st_ready && vic_ready, "R9 victim before store", {st_ready, vic_ready}, 2'b01);
    model_write(28'h90, vic_data, 16'hFFFF);
    @(negedge clk);
    vic_valid = 1'b0;
    drive_store(32'h904, 32'h000000AB, 4'h1); model_store(32'h904, 32'h000000AB, 4'h1);
    @(negedge clk);
    st_valid = 1'b0; #1;
    chk(mem_mask == 16'hFFFF, "R9 victim full mask", 128'(mem_mask), 128'hFFFF);
    drain("R9 victim");

    // R1: reset clears pending slots
    drive_store(32'hB00, 32'h1, 4'hF);
    @(negedge clk);
    st_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; #1;
    chk(!mem_valid && st_ready && vic_ready, "R1 reset drops slots", {mem_valid, st_ready, vic_ready}, 3'b011);
    m_n = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule